// File: doc/BRIEF.md
# Binary Content-Addressable Memory

This block is a small binary lookup table. It has a parameterised number of entries and a parameterised word width, and each entry holds a data word and an occupancy flag. There are two request ports.

- The **access port** works like an ordinary RAM port. It performs exactly one of three actions on the single entry picked by its address: read, write or invalidate.
- The **search port** presents a key. That key is compared with every occupied entry in the same cycle.

Every entry has its own exact comparator. The hit lines from all the comparators go to a priority encoder. The encoder picks the lowest matching index and produces a hit flag, which tells the caller whether the key was found at all.

Both ports may issue a request in the same cycle. A search always sees the table as it stood before that cycle's access took effect. Search results and read data are registered, so they appear one clock after the request. Each result comes with its own strobe.

Top module: `cam_core`

## Requirements
- R1: A synchronous active-low reset marks every entry unoccupied and drives `srch_done`, `hit`, `hit_idx` and `rd_ack` to zero. A search issued right after reset therefore misses.
- R2: An access with op code 1 (write) stores `acc_wdata` at `acc_addr` and marks that entry occupied. A later read (op code 0) returns the word on `rd_data` and the occupancy flag on `rd_vld_bit`, with `rd_ack` high, one cycle after the read request. `rd_ack` is low in every other cycle.
- R3: An access with op code 2 (invalidate) marks the addressed entry unoccupied and keeps its stored word. A later read returns the old word with `rd_vld_bit` low, and the entry no longer matches any key.
- R4: An entry matches only if it is occupied and all WIDTH bits of its word equal the key. A key that differs in a single bit misses.
- R5: When several occupied entries match, `hit_idx` reports the lowest matching index.
- R6: Whenever `hit` is low, `hit_idx` is zero.
- R7: `srch_done` is high exactly in the cycle after a cycle with `srch_req` high. `hit` and `hit_idx` update in that cycle and hold their values until the next search.
- R8: A write or invalidate issued in the same cycle as a search has no effect on that search's result. It does affect the next search.
- R9: Op code 3 on the access port changes no entry and produces no `rd_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_req | input | 1 | Access request strobe |
| acc_op | input | 2 | 0 read, 1 write, 2 invalidate, 3 no operation |
| acc_addr | input | AW | Entry index for the access |
| acc_wdata | input | WIDTH | Word to store on a write |
| srch_req | input | 1 | Search request strobe |
| srch_key | input | WIDTH | Key to look up |
| rd_ack | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | WIDTH | Word stored in the entry that was read |
| rd_vld_bit | output | 1 | Occupancy flag of the entry that was read |
| srch_done | output | 1 | Search result valid, one cycle after a search |
| hit | output | 1 | At least one occupied entry matched |
| hit_idx | output | AW | Lowest matching index, zero on a miss |

## Verification
Most internal faults surface at the ports on the search that follows them.

- A corrupted occupancy flag shows up as a hit or miss that contradicts the table contents. A read of that entry also exposes it directly through `rd_vld_bit`.
- A broken comparator bit shows up on the next search whose key differs from a stored word only in that bit.
- A wrong encoder order shows up as the wrong `hit_idx` as soon as two entries hold the same word.
- A search that sees a write from its own cycle returns a result one cycle too early. The bench issues searches and writes to the same word together, so this error is exposed in the very next result.

// File: rtl/cam_pkg.sv
// Package: shared encodings for the lookup table.
// Assumes: the access port carries a two-bit op code.
package cam_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_INVAL = 2'd2,
        ACC_NOP   = 2'd3
    } acc_op_t;
endpackage

// File: rtl/cam_store.sv
// Module: cam_store
// Holds the word array and the occupancy flags. Decodes the access address
// into per-entry strobes and registers read data.
// Assumes: one access per cycle; out-of-range addresses touch nothing.
module cam_store
    import cam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 16,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           acc_req,
    input  logic [1:0]                     acc_op,
    input  logic [AW-1:0]                  acc_addr,
    input  logic [WIDTH-1:0]               acc_wdata,
    output logic [ENTRIES-1:0][WIDTH-1:0]  words,
    output logic [ENTRIES-1:0]             occupied,
    output logic                           rd_ack,
    output logic [WIDTH-1:0]               rd_data,
    output logic                           rd_vld_bit
);
    logic [ENTRIES-1:0] wr_sel;
    logic [ENTRIES-1:0] inv_sel;
    logic               rd_go;

    assign rd_go = acc_req && (acc_op == ACC_READ);

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        // Address decoder: one strobe per entry and command.
        assign wr_sel[i]  = acc_req && (acc_op == ACC_WRITE) && (acc_addr == AW'(i));
        assign inv_sel[i] = acc_req && (acc_op == ACC_INVAL) && (acc_addr == AW'(i));

        // Word storage: load on write; contents are not reset.
        always_ff @(posedge clk) begin
            if (wr_sel[i]) words[i] <= acc_wdata;
        end

        // Occupancy flag: cleared by reset or invalidate, set by write.
        always_ff @(posedge clk) begin
            if (!rst_n)          occupied[i] <= 1'b0;
            else if (wr_sel[i])  occupied[i] <= 1'b1;
            else if (inv_sel[i]) occupied[i] <= 1'b0;
        end
    end

    // Read path: register the addressed word and flag with a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ack     <= 1'b0;
            rd_data    <= '0;
            rd_vld_bit <= 1'b0;
        end else begin
            rd_ack <= rd_go;
            if (rd_go && (int'(acc_addr) < ENTRIES)) begin
                rd_data    <= words[acc_addr];
                rd_vld_bit <= occupied[acc_addr];
            end else if (rd_go) begin
                rd_data    <= '0;
                rd_vld_bit <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cam_match.sv
// Module: cam_match
// Compares the key against every entry at once and produces one hit line
// per entry.
// Assumes: an unoccupied entry never hits, whatever it holds.
module cam_match #(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 16
) (
    input  logic [ENTRIES-1:0][WIDTH-1:0] words,
    input  logic [ENTRIES-1:0]            occupied,
    input  logic [WIDTH-1:0]              key,
    output logic [ENTRIES-1:0]            hits
);
    for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
        // Full-width equality gated by occupancy.
        assign hits[i] = occupied[i] && (words[i] == key);
    end
endmodule

// File: rtl/cam_prio.sv
// Module: cam_prio
// Priority encoder: the lowest set hit line wins. Reports its index and
// whether any hit line is set.
// Assumes: the index is zero when nothing hits.
module cam_prio #(
    parameter int ENTRIES = 8,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] hits,
    output logic               found,
    output logic [AW-1:0]      idx
);
    // Scan from the top down so the lowest hit is written last.
    always_comb begin
        idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) idx = AW'(i);
        end
    end

    assign found = |hits;
endmodule

// File: rtl/cam_core.sv
// Module: cam_core (top)
// Binary lookup table: addressed read/write/invalidate plus a parallel
// search with lowest-index priority. Search results are registered.
// Assumes: a search compares against the table before any same-cycle access.
module cam_core
    import cam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 16,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_req,
    input  logic [1:0]       acc_op,
    input  logic [AW-1:0]    acc_addr,
    input  logic [WIDTH-1:0] acc_wdata,
    input  logic             srch_req,
    input  logic [WIDTH-1:0] srch_key,
    output logic             rd_ack,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_vld_bit,
    output logic             srch_done,
    output logic             hit,
    output logic [AW-1:0]    hit_idx
);
    logic [ENTRIES-1:0][WIDTH-1:0] words;
    logic [ENTRIES-1:0]            occupied;
    logic [ENTRIES-1:0]            hits;
    logic                          found;
    logic [AW-1:0]                 win_idx;

    cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_req    (acc_req),
        .acc_op     (acc_op),
        .acc_addr   (acc_addr),
        .acc_wdata  (acc_wdata),
        .words      (words),
        .occupied   (occupied),
        .rd_ack     (rd_ack),
        .rd_data    (rd_data),
        .rd_vld_bit (rd_vld_bit)
    );

    cam_match #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_match (
        .words    (words),
        .occupied (occupied),
        .key      (srch_key),
        .hits     (hits)
    );

    cam_prio #(.ENTRIES(ENTRIES)) u_prio (
        .hits  (hits),
        .found (found),
        .idx   (win_idx)
    );

    // Search result register: capture on request, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srch_done <= 1'b0;
            hit       <= 1'b0;
            hit_idx   <= '0;
        end else begin
            srch_done <= srch_req;
            if (srch_req) begin
                hit     <= found;
                hit_idx <= found ? win_idx : '0;
            end
        end
    end
endmodule

// File: rtl/cam_core_chk.sv
// Module: cam_core_chk
// Port-level temporal checks on cam_core. Attached to the top by bind.
// Assumes: inputs are driven to zero while reset is held.
module cam_core_chk
    import cam_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int WIDTH   = 16,
    localparam int AW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             acc_req,
    input logic [1:0]       acc_op,
    input logic [AW-1:0]    acc_addr,
    input logic [WIDTH-1:0] acc_wdata,
    input logic             srch_req,
    input logic             rd_ack,
    input logic [WIDTH-1:0] rd_data,
    input logic             rd_vld_bit,
    input logic             srch_done,
    input logic             hit,
    input logic [AW-1:0]    hit_idx
);
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!srch_done && !hit && !rd_ack));

    a_r7_done_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        srch_req |=> srch_done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_req |=> !srch_done);

    a_r6_miss_idx_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_idx == '0));

    a_r2_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_op == ACC_READ) |=> rd_ack);

    a_r9_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_req && acc_op == ACC_READ) |=> !rd_ack);

    a_r2_write_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_req && acc_op == ACC_WRITE) && acc_req && acc_op == ACC_READ
         && acc_addr == $past(acc_addr))
        |=> (rd_vld_bit && rd_data == $past(acc_wdata, 2)));

    a_r3_inval_then_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(acc_req && acc_op == ACC_INVAL) && acc_req && acc_op == ACC_READ
         && acc_addr == $past(acc_addr))
        |=> !rd_vld_bit);
endmodule

bind cam_core cam_core_chk #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_req    (acc_req),
    .acc_op     (acc_op),
    .acc_addr   (acc_addr),
    .acc_wdata  (acc_wdata),
    .srch_req   (srch_req),
    .rd_ack     (rd_ack),
    .rd_data    (rd_data),
    .rd_vld_bit (rd_vld_bit),
    .srch_done  (srch_done),
    .hit        (hit),
    .hit_idx    (hit_idx)
);

// File: tb/test_cam_core.sv
// Bench for cam_core: a vector table walked by one loop, then directed
// tests for read-back, result holding and reset in mid-run.
module test_cam_core;
    localparam int ENTRIES = 8;
    localparam int WIDTH   = 16;
    localparam int AW      = 3;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             acc_req;
    logic [1:0]       acc_op;
    logic [AW-1:0]    acc_addr;
    logic [WIDTH-1:0] acc_wdata;
    logic             srch_req;
    logic [WIDTH-1:0] srch_key;
    logic             rd_ack;
    logic [WIDTH-1:0] rd_data;
    logic             rd_vld_bit;
    logic             srch_done;
    logic             hit;
    logic [AW-1:0]    hit_idx;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;

    cam_core #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) i_cam_core (
        .clk(clk), .rst_n(rst_n),
        .acc_req(acc_req), .acc_op(acc_op), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
        .srch_req(srch_req), .srch_key(srch_key),
        .rd_ack(rd_ack), .rd_data(rd_data), .rd_vld_bit(rd_vld_bit),
        .srch_done(srch_done), .hit(hit), .hit_idx(hit_idx)
    );

    typedef struct packed {
        logic             areq;
        logic [1:0]       op;
        logic [AW-1:0]    addr;
        logic [WIDTH-1:0] wdata;
        logic             sreq;
        logic [WIDTH-1:0] key;
        logic             ehit;
        logic [AW-1:0]    eidx;
    } vec_t;

    // op: 0 read, 1 write, 2 invalidate, 3 nop
    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'h1234, 1'b0, 3'd0}, // R1 miss after reset
        '{1'b1, 2'd1, 3'd3, 16'hABCD, 1'b0, 16'h0000, 1'b0, 3'd0},
        '{1'b1, 2'd1, 3'd5, 16'hABCD, 1'b0, 16'h0000, 1'b0, 3'd0},
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'hABCD, 1'b1, 3'd3}, // R5 3 beats 5
        '{1'b1, 2'd1, 3'd1, 16'hABCD, 1'b1, 16'hABCD, 1'b1, 3'd3}, // R8 write unseen
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'hABCD, 1'b1, 3'd1}, // R8 seen next
        '{1'b1, 2'd2, 3'd1, 16'h0000, 1'b1, 16'hABCD, 1'b1, 3'd1}, // R8 inval unseen
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'hABCD, 1'b1, 3'd3}, // R3 inval seen
        '{1'b1, 2'd2, 3'd3, 16'h0000, 1'b0, 16'h0000, 1'b0, 3'd0},
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'hABCD, 1'b1, 3'd5}, // R5 only 5 left
        '{1'b1, 2'd1, 3'd0, 16'h0000, 1'b1, 16'h0000, 1'b0, 3'd0}, // R8/R6 miss
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'h0000, 1'b1, 3'd0}, // R4 zero word
        '{1'b1, 2'd3, 3'd0, 16'h5555, 1'b1, 16'h0000, 1'b1, 3'd0}, // R9 nop
        '{1'b1, 2'd2, 3'd5, 16'h0000, 1'b1, 16'hABCD, 1'b1, 3'd5},
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'hABCD, 1'b0, 3'd0}, // R3 all gone
        '{1'b1, 2'd1, 3'd7, 16'hFFFF, 1'b1, 16'hFFFF, 1'b0, 3'd0},
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'hFFFF, 1'b1, 3'd7}, // R4 top entry
        '{1'b0, 2'd0, 3'd0, 16'h0000, 1'b1, 16'hFFFE, 1'b0, 3'd0}  // R4 one-bit miss
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        acc_req = 0; acc_op = 0; acc_addr = 0; acc_wdata = 0;
        srch_req = 0; srch_key = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        idle_inputs();
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [WIDTH-1:0] ed,
                           input logic ev, input bit chk_data, input string req);
        @(negedge clk);
        idle_inputs();
        acc_req = 1; acc_op = 2'd0; acc_addr = a;
        @(posedge clk); #1;
        check(req, {31'd0, rd_ack}, 32'd1);
        check(req, {31'd0, rd_vld_bit}, {31'd0, ev});
        if (chk_data) check(req, {16'd0, rd_data}, {16'd0, ed});
    endtask

    task automatic do_search(input logic [WIDTH-1:0] k, input logic eh,
                             input logic [AW-1:0] ei, input string req);
        @(negedge clk);
        idle_inputs();
        srch_req = 1; srch_key = k;
        @(posedge clk); #1;
        check(req, {31'd0, srch_done}, 32'd1);
        check(req, {31'd0, hit}, {31'd0, eh});
        check(req, {29'd0, hit_idx}, {29'd0, ei});
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        rst_n = 0;
        idle_inputs();
        do_reset();
        // R1: quiet outputs after reset
        check("R1", {29'd0, srch_done, hit, rd_ack}, 32'd0);
        check("R1", {29'd0, hit_idx}, 32'd0);

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            acc_req = VECS[v].areq; acc_op = VECS[v].op; acc_addr = VECS[v].addr;
            acc_wdata = VECS[v].wdata; srch_req = VECS[v].sreq; srch_key = VECS[v].key;
            @(posedge clk); #1;
            // R7: done strobe follows the request by one cycle
            check("R7", {31'd0, srch_done}, {31'd0, VECS[v].sreq});
            if (VECS[v].sreq) begin
                check("R4/R5", {31'd0, hit}, {31'd0, VECS[v].ehit});
                check("R5/R6", {29'd0, hit_idx}, {29'd0, VECS[v].eidx});
            end
            // R9: only reads acknowledge
            check("R9", {31'd0, rd_ack}, {31'd0, VECS[v].areq && VECS[v].op == 2'd0});
        end

        // R7: after the last search (FFFE miss), a search of FFFF then idle holds
        do_search(16'hFFFF, 1'b1, 3'd7, "R7");
        @(negedge clk); idle_inputs();
        @(posedge clk); #1;
        check("R7", {31'd0, srch_done}, 32'd0);
        check("R7", {31'd0, hit}, 32'd1);
        check("R7", {29'd0, hit_idx}, 32'd7);

        // R2: read back written entry
        do_read(3'd7, 16'hFFFF, 1'b1, 1'b1, "R2");
        do_read(3'd0, 16'h0000, 1'b1, 1'b1, "R2/R9");
        // R3: invalidated entries keep their word, flag low
        do_read(3'd5, 16'hABCD, 1'b0, 1'b1, "R3");
        do_read(3'd1, 16'hABCD, 1'b0, 1'b1, "R3");
        // R2: entry never written reads unoccupied
        do_read(3'd6, 16'h0000, 1'b0, 1'b0, "R2");

        // R1: reset in mid-run clears occupancy
        do_reset();
        check("R1", {29'd0, srch_done, hit, rd_ack}, 32'd0);
        do_search(16'hFFFF, 1'b0, 3'd0, "R1");
        do_read(3'd7, 16'hFFFF, 1'b0, 1'b0, "R1");

        finish_run();
    end
endmodule